// File: doc/BRIEF.md
# Metaframe Generator with Burst Gating

The block produces one transmit word per clock for a single lane and groups the words into metaframes. Every metaframe opens with three framing control words: a synchronization word, a scrambler-state word and a skip word. Payload slots follow, and a diagnostic word closes the metaframe. A one-cycle frame-start pulse comes out alongside the synchronization word. Each output word carries a control flag, so framing and filler words can be told apart from payload.

Payload is taken from an upstream first-word-fall-through FIFO. The FIFO presents its head word together with an empty flag, and the block pops that word with a combinational read strobe in the same cycle. Three values are captured once, in the cycle that starts a metaframe, and they govern that whole metaframe: the configured length, a burst-enable bit and a 2-bit lane status. When burst is off, every payload slot is filled with a SKIP word and no reads are issued. When burst is on, each payload slot pops one FIFO word. If the FIFO is empty in a payload slot, a SKIP word goes out in that slot instead. The captured lane status is written into the diagnostic word.

Top module: `mframe_gen`

## Requirements
- R1: While rst_ni is low, word_o, word_ctrl_o, frame_start_o and fifo_rd_o are all 0.
- R2: Within a metaframe, position 0 is the sync word, position 1 is the scrambler-state word, position 2 is the skip word and the last position is the diagnostic word. The control type code sits in word bits [63:58]: sync 0x1E, scrambler-state 0x0A, skip 0x03, diagnostic 0x19. All other bits of the sync, scrambler-state and skip words are 0, and every one of these words has word_ctrl_o = 1.
- R3: A metaframe lasts exactly the configured number of words, with no gap between consecutive metaframes.
- R4: A configured length below 4 is treated as 4.
- R5: A configured length above MAX_LEN is treated as MAX_LEN.
- R6: cfg_len_i is sampled only in the first cycle of a metaframe. Changing it at any other time does not alter the current metaframe.
- R7: If burst_en_i was 0 when the metaframe started, fifo_rd_o stays 0 for the whole metaframe, and every payload slot carries the skip word with word_ctrl_o = 1.
- R8: If burst_en_i was 1 when the metaframe started, each payload slot with fifo_empty_i = 0 raises fifo_rd_o for that cycle. One cycle later the slot's output word is the fifo_data_i value from that cycle, with word_ctrl_o = 0.
- R9: In burst mode, a payload slot that sees fifo_empty_i = 1 issues no read and carries the skip word.
- R10: burst_en_i is sampled only in the first cycle of a metaframe. A later change does not affect the current metaframe's payload slots.
- R11: The diagnostic word holds the lane_stat_i value sampled in the first cycle of its metaframe in bits [33:32]. All its other bits below [58] are 0.
- R12: frame_start_o is high for exactly one cycle per metaframe, in the same cycle that the sync word is on word_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len_i | input | LEN_W | Metaframe length in words |
| burst_en_i | input | 1 | Payload source select for the next metaframe (1 = FIFO, 0 = SKIP fill) |
| lane_stat_i | input | 2 | Lane status that is carried into the diagnostic word |
| fifo_empty_i | input | 1 | Upstream FIFO has no word |
| fifo_data_i | input | DATA_W | Head word of the FIFO |
| fifo_rd_o | output | 1 | Pops the FIFO head word in this cycle |
| word_o | output | DATA_W | Transmit word |
| word_ctrl_o | output | 1 | 1 = control or filler word, 0 = payload |
| frame_start_o | output | 1 | Marks the first word of a metaframe |

## Verification
The bench builds the block with LEN_W = 7, MAX_LEN = 40 and DATA_W = 64. Because MAX_LEN is small, a configured length of 100 exercises the upper clamp in a 40-word metaframe, and short lengths of 0, 2 and 5 exercise the lower clamp and a frame with a single payload slot. The bench changes burst enable, lane status and length in the middle of metaframes while keeping them clear of the frame-start windows, so it can show that each is captured only once per metaframe. One burst metaframe runs against a FIFO that reports empty in every third slot.

// File: rtl/mframe_pkg.sv
`timescale 1ns/1ps
package mframe_pkg;

  localparam int CODE_W    = 6;
  localparam int MIN_WORDS = 4;   // sync + scrambler + skip + diag

  localparam logic [CODE_W-1:0] CODE_SYNC  = 6'h1E;
  localparam logic [CODE_W-1:0] CODE_SCRAM = 6'h0A;
  localparam logic [CODE_W-1:0] CODE_SKIP  = 6'h03;
  localparam logic [CODE_W-1:0] CODE_DIAG  = 6'h19;

  localparam int STAT_LSB = 32;

  typedef enum logic [2:0] {
    SL_SYNC,
    SL_SCRAM,
    SL_SKIP,
    SL_PAYLOAD,
    SL_DIAG
  } slot_e;

endpackage

// File: rtl/mframe_seq.sv
`timescale 1ns/1ps
module mframe_seq
  import mframe_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MAX_LEN = 8192
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] cfg_len_i,
  output slot_e            slot_o,
  output logic             sof_o
);

  localparam logic [LEN_W-1:0] LAST_MIN = LEN_W'(MIN_WORDS - 1);
  localparam logic [LEN_W-1:0] LAST_MAX = LEN_W'(MAX_LEN - 1);

  logic [LEN_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] last_q, last_d;
  logic [LEN_W-1:0] last_cfg;

  // clamp configured length into [MIN_WORDS, MAX_LEN], expressed as last index
  always_comb begin
    if (int'(cfg_len_i) < MIN_WORDS)     last_cfg = LAST_MIN;
    else if (int'(cfg_len_i) > MAX_LEN)  last_cfg = LAST_MAX;
    else                                 last_cfg = cfg_len_i - LEN_W'(1);
  end

  assign sof_o = (pos_q == '0);

  always_comb begin
    last_d = sof_o ? last_cfg : last_q;
    if (sof_o)                pos_d = LEN_W'(1);
    else if (pos_q == last_q) pos_d = '0;
    else                      pos_d = pos_q + LEN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      last_q <= LAST_MIN;
    end else begin
      pos_q  <= pos_d;
      last_q <= last_d;
    end
  end

  // last_q only valid from position 1; positions 0..2 are fixed framing
  always_comb begin
    unique case (pos_q)
      LEN_W'(0): slot_o = SL_SYNC;
      LEN_W'(1): slot_o = SL_SCRAM;
      LEN_W'(2): slot_o = SL_SKIP;
      default:   slot_o = (pos_q == last_q) ? SL_DIAG : SL_PAYLOAD;
    endcase
  end

  AST_LAST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_q >= LAST_MIN) && (last_q <= LAST_MAX)); // R5

  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= last_q); // R3

  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_o |=> $stable(last_q)); // R6

  AST_WRAP_TO_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o == SL_DIAG) |=> sof_o); // R3

endmodule

// File: rtl/mframe_gate.sv
`timescale 1ns/1ps
module mframe_gate
  import mframe_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  slot_e slot_i,
  input  logic  sof_i,
  input  logic  burst_en_i,
  input  logic  fifo_empty_i,
  output logic  fifo_rd_o,
  output logic  fill_skip_o
);

  logic burst_q;
  logic payload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    burst_q <= 1'b0;
    else if (sof_i) burst_q <= burst_en_i;
  end

  assign payload     = (slot_i == SL_PAYLOAD);
  assign fifo_rd_o   = payload && burst_q && !fifo_empty_i;
  assign fill_skip_o = payload && !fifo_rd_o;

  AST_BURST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(burst_q)); // R10

  AST_NO_RD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_q && !sof_i) |-> !fifo_rd_o); // R7

  AST_NO_RD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty_i |-> !fifo_rd_o); // R9

  AST_RD_ONLY_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i != SL_PAYLOAD) |-> !fifo_rd_o); // R8

endmodule

// File: rtl/mframe_fmt.sv
`timescale 1ns/1ps
module mframe_fmt
  import mframe_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_e             slot_i,
  input  logic              sof_i,
  input  logic              fill_skip_i,
  input  logic [1:0]        lane_stat_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_ctrl_o,
  output logic              frame_start_o
);

  localparam int BODY_W = DATA_W - CODE_W;

  logic [1:0]        stat_q;
  logic [DATA_W-1:0] word_d;
  logic              ctrl_d;
  logic [BODY_W-1:0] diag_body;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= 2'b00;
    else if (sof_i) stat_q <= lane_stat_i;
  end

  // low 32 bits reserved for CRC; left zero here
  always_comb begin
    diag_body = '0;
    diag_body[STAT_LSB +: 2] = stat_q;
  end

  always_comb begin
    ctrl_d = 1'b1;
    unique case (slot_i)
      SL_SYNC:  word_d = {CODE_SYNC,  BODY_W'(0)};
      SL_SCRAM: word_d = {CODE_SCRAM, BODY_W'(0)};
      SL_SKIP:  word_d = {CODE_SKIP,  BODY_W'(0)};
      SL_DIAG:  word_d = {CODE_DIAG,  diag_body};
      default: begin
        if (fill_skip_i) begin
          word_d = {CODE_SKIP, BODY_W'(0)};
        end else begin
          word_d = fifo_data_i;
          ctrl_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o        <= '0;
      word_ctrl_o   <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      word_o        <= word_d;
      word_ctrl_o   <= ctrl_d;
      frame_start_o <= sof_i;
    end
  end

  AST_FS_ON_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (word_ctrl_o && word_o[DATA_W-1 -: CODE_W] == CODE_SYNC)); // R12

  AST_FS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o); // R12

  AST_STAT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(stat_q)); // R11

endmodule

// File: rtl/mframe_gen.sv
`timescale 1ns/1ps
module mframe_gen
  import mframe_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int LEN_W   = 14,
  parameter int MAX_LEN = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              burst_en_i,
  input  logic [1:0]        lane_stat_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_ctrl_o,
  output logic              frame_start_o
);

  initial begin
    assert (DATA_W >= STAT_LSB + 2 + CODE_W) else $error("DATA_W too small");
    assert (MAX_LEN >= MIN_WORDS && MAX_LEN <= (1 << LEN_W)) else $error("MAX_LEN out of range");
  end

  slot_e slot;
  logic  sof;
  logic  fill_skip;

  mframe_seq #(
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_len_i (cfg_len_i),
    .slot_o    (slot),
    .sof_o     (sof)
  );

  mframe_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_i       (slot),
    .sof_i        (sof),
    .burst_en_i   (burst_en_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_rd_o    (fifo_rd_o),
    .fill_skip_o  (fill_skip)
  );

  mframe_fmt #(
    .DATA_W (DATA_W)
  ) u_fmt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .slot_i        (slot),
    .sof_i         (sof),
    .fill_skip_i   (fill_skip),
    .lane_stat_i   (lane_stat_i),
    .fifo_data_i   (fifo_data_i),
    .word_o        (word_o),
    .word_ctrl_o   (word_ctrl_o),
    .frame_start_o (frame_start_o)
  );

  AST_RD_GIVES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> !word_ctrl_o); // R8

  AST_RD_DATA_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> (word_o == $past(fifo_data_i))); // R8

endmodule

// File: tb/mframe_gen_tb_top.sv
`timescale 1ns/1ps
module mframe_gen_tb_top;

  localparam int DATA_W  = 64;
  localparam int LEN_W   = 7;
  localparam int MAX_LEN = 40;

  typedef struct {
    logic [DATA_W-1:0] word;
    logic              ctrl;
    logic              fs;
    string             tag;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [LEN_W-1:0]  cfg_len_i = '0;
  logic              burst_en_i = 1'b0;
  logic [1:0]        lane_stat_i = 2'b00;
  logic              fifo_empty_i = 1'b1;
  logic [DATA_W-1:0] fifo_data_i = '0;
  logic              fifo_rd_o;
  logic [DATA_W-1:0] word_o;
  logic              word_ctrl_o;
  logic              frame_start_o;

  int   n_checks = 0;
  int   n_errors = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  mframe_gen #(
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN)
  ) dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_len_i     (cfg_len_i),
    .burst_en_i    (burst_en_i),
    .lane_stat_i   (lane_stat_i),
    .fifo_empty_i  (fifo_empty_i),
    .fifo_data_i   (fifo_data_i),
    .fifo_rd_o     (fifo_rd_o),
    .word_o        (word_o),
    .word_ctrl_o   (word_ctrl_o),
    .frame_start_o (frame_start_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic int eff_len(int l);
    if (l < 4) return 4;
    if (l > MAX_LEN) return MAX_LEN;
    return l;
  endfunction

  function automatic logic [DATA_W-1:0] ctl_word(logic [5:0] code, logic [1:0] st);
    logic [DATA_W-1:0] w;
    w = '0;
    w[63:58] = code;
    if (code == 6'h19) w[33:32] = st;
    return w;
  endfunction

  task automatic check_rd(logic exp_rd, string tag);
    n_checks++;
    if (fifo_rd_o !== exp_rd) begin
      n_errors++;
      $display("FAIL %s fifo_rd_o actual=%b expected=%b at cycle %0d", tag, fifo_rd_o, exp_rd, cyc);
    end
  endtask

  // one metaframe of stimulus; burst/stat must already equal the args at start
  task automatic run_frame(int len, bit burst, bit [1:0] st, bit emp_mode,
                           int chg_at, bit nburst, bit [1:0] nst, string ftag);
    int   l_eff = eff_len(len);
    exp_t e;
    for (int p = 0; p < l_eff; p++) begin
      if (p == 0) begin
        cfg_len_i   = LEN_W'(len);
        burst_en_i  = burst;
        lane_stat_i = st;
      end
      if (chg_at > 0 && p == chg_at) begin
        burst_en_i  = nburst;
        lane_stat_i = nst;
        cfg_len_i   = LEN_W'(9);   // R6: mid-frame length change must not matter
      end
      fifo_empty_i = emp_mode && (p % 3 == 0);
      fifo_data_i  = {16'hC0DE, 16'h0000, 32'(cyc)};
      e.fs   = (p == 0);
      e.ctrl = 1'b1;
      if (p == 0)              begin e.word = ctl_word(6'h1E, st); e.tag = "R2 R12"; end
      else if (p == 1)         begin e.word = ctl_word(6'h0A, st); e.tag = "R2"; end
      else if (p == 2)         begin e.word = ctl_word(6'h03, st); e.tag = "R2"; end
      else if (p == l_eff - 1) begin e.word = ctl_word(6'h19, st); e.tag = "R11 R3"; end
      else if (!burst)         begin e.word = ctl_word(6'h03, st); e.tag = "R7 R10"; end
      else if (fifo_empty_i)   begin e.word = ctl_word(6'h03, st); e.tag = "R9"; end
      else begin e.word = fifo_data_i; e.ctrl = 1'b0; e.tag = "R8 R10"; end
      e.tag = {e.tag, " ", ftag};
      #1;
      check_rd(burst && p >= 3 && p < l_eff - 1 && !fifo_empty_i, e.tag);
      sb_q.push_back(e);
      @(negedge clk_i);
    end
  endtask

  // monitor: pops one expected word per clock after the register stage
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      cyc++;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (word_o !== e.word || word_ctrl_o !== e.ctrl || frame_start_o !== e.fs) begin
          n_errors++;
          $display("FAIL %s word actual=%h/%b/%b expected=%h/%b/%b",
                   e.tag, word_o, word_ctrl_o, frame_start_o, e.word, e.ctrl, e.fs);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    n_checks++;
    if (word_o !== '0 || word_ctrl_o !== 1'b0 || frame_start_o !== 1'b0 || fifo_rd_o !== 1'b0) begin
      n_errors++;
      $display("FAIL R1 reset outputs actual=%h/%b/%b/%b expected=0/0/0/0",
               word_o, word_ctrl_o, frame_start_o, fifo_rd_o);
    end
    burst_en_i  = 1'b0;
    lane_stat_i = 2'd2;
    rst_ni      = 1'b1;
    run_frame(16, 1'b0, 2'd2, 1'b0, 8, 1'b1, 2'd1, "R7");
    run_frame(16, 1'b1, 2'd1, 1'b0, 8, 1'b1, 2'd3, "R8");
    run_frame(20, 1'b1, 2'd3, 1'b1, 10, 1'b0, 2'd0, "R9");
    run_frame(2,  1'b0, 2'd0, 1'b0, 0, 1'b0, 2'd0, "R4");
    run_frame(0,  1'b0, 2'd0, 1'b0, 0, 1'b0, 2'd0, "R4");
    run_frame(12, 1'b0, 2'd0, 1'b0, 6, 1'b1, 2'd2, "R6");
    run_frame(100, 1'b1, 2'd2, 1'b0, 20, 1'b0, 2'd1, "R5");
    run_frame(5,  1'b0, 2'd1, 1'b0, 0, 1'b0, 2'd1, "R4");
    run_frame(40, 1'b0, 2'd1, 1'b0, 20, 1'b1, 2'd3, "R3");
    run_frame(14, 1'b1, 2'd3, 1'b0, 7, 1'b1, 2'd3, "R10");
    repeat (3) @(negedge clk_i);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_errors++;
      $display("FAIL R3 scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule